// File: doc/BRIEF.md
# Threshold Multiplicity Counter and Packer

This block turns a stream of per-position threshold results into per-region object multiplicities. Each input word holds four 3-bit codes, one per phi slot. A code gives the highest threshold that the object in that slot passed, and zero means it passed none. Every input word is tagged with an algorithm index, an eta slice index and a region index. Over one frame the block counts, for every (algorithm, eta, region) address, how many objects passed each of six thresholds. A threshold count includes every object whose code is at or above that threshold. Each count is a 2-bit field that saturates.

A start-of-frame strobe clears all counts. An end-of-frame strobe takes a snapshot of the counts and starts a burst of 36 packed 12-bit result words, one for each address, in a fixed order. Inputs that arrive during the burst go into the counts of the following frame and do not change the words being sent. An input whose algorithm or region tag is out of range is dropped and sets a sticky error flag.

Top module: `thr_mult_packer`

## Requirements
- R1: While reset is held and after it is released, out_valid is 0, out_word is 0 and tag_err is 0.
- R2: The code for slot s (s = 0..3) sits in bits 3s+2:3s of in_word. An object with code c adds one to the count of every threshold k with 1 <= k <= min(c,6). Code 0 adds nothing, and code 7 counts the same as code 6.
- R3: In every result word the threshold-k count (k = 1..6) occupies bits 2k-1:2k-2. Threshold 1 is in bits 1:0 and threshold 6 is in bits 11:10.
- R4: Each count saturates at 3 and never wraps, however many objects add to it within a frame.
- R5: A cycle with sof high clears all counts. An input that is valid in that same cycle is counted in the new frame.
- R6: In the cycle after eof is high, out_valid goes high and stays high for exactly 36 consecutive cycles. Word n comes from address n = (alg*4 + eta)*3 + region, where alg is 0..2, eta is 0..3 for slices 2..5, and region is 0 south, 1 central, 2 north. An input that is valid in the eof cycle is included. An eof during a burst restarts it at word 0 with a fresh snapshot.
- R7: An input with in_reg = 3 or in_alg = 3 changes no count. tag_err is high from the cycle after such an input and stays high until reset.
- R8: Inputs that arrive while a burst is being sent do not change that burst. They do accumulate into the counts that the next eof reports, unless sof intervenes.
- R9: Several valid inputs to the same address within a frame add up per threshold, subject to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Start-of-frame strobe, clears counts |
| eof | input | 1 | End-of-frame strobe, snapshots and starts emission |
| in_valid | input | 1 | Input word valid |
| in_alg | input | 2 | Algorithm tag, 0..2 valid |
| in_eta | input | 2 | Eta slice tag, 0..3 for slices 2..5 |
| in_reg | input | 2 | Region tag, 0 south, 1 central, 2 north |
| in_word | input | 12 | Four packed 3-bit highest-threshold codes |
| out_valid | output | 1 | Result word valid |
| out_word | output | 12 | Six packed 2-bit saturating counts |
| tag_err | output | 1 | Sticky flag for an input with an invalid tag |

## Verification
Two pairs of events can fall in the same cycle: a counted input with a frame boundary, and a counted input with an ongoing burst. The bench drives a valid input together with sof and together with eof. It expects the first input to appear only in the new frame and the second to appear in the burst that this same eof starts. It also feeds random inputs throughout every burst and a restarting eof partway through one. A model that keeps separate live counts and a snapshot judges every emitted word cycle by cycle.

// File: rtl/thr_mult_pkg.sv
package thr_mult_pkg;
   typedef enum logic [0:0] {
      EMIT_IDLE = 1'b0,
      EMIT_RUN  = 1'b1
   } emit_st_e;

   localparam int TMC_MAX_THR_BITS = 3;
endpackage

// File: rtl/tmc_unpack.sv
module tmc_unpack #(
   parameter int CODE_W = 3,
   parameter int SLOTS  = 4,
   parameter int N_THR  = 6,
   parameter int INC_W  = 3
) (
   input  logic [CODE_W*SLOTS-1:0] word,
   output logic [N_THR*INC_W-1:0]  incs
);
   for (genvar k = 0; k < N_THR; k++) begin : g_thr
      logic [INC_W-1:0] n;
      always_comb begin
         n = '0;
         for (int s = 0; s < SLOTS; s++) begin
            if (word[s*CODE_W +: CODE_W] >= CODE_W'(k + 1)) n = n + 1'b1;
         end
      end
      assign incs[k*INC_W +: INC_W] = n;
   end
endmodule

// File: rtl/tmc_acc.sv
module tmc_acc #(
   parameter int N_WORDS = 36,
   parameter int N_THR   = 6,
   parameter int CNT_W   = 2,
   parameter int INC_W   = 3,
   parameter int IDX_W   = 6
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                clr,
   input  logic                                hit,
   input  logic [IDX_W-1:0]                    idx,
   input  logic [N_THR*INC_W-1:0]              incs,
   output logic [N_WORDS-1:0][N_THR*CNT_W-1:0] live_nxt
);
   localparam int FW    = N_THR * CNT_W;
   localparam int SW    = CNT_W + INC_W;
   localparam int C_MAX = (1 << CNT_W) - 1;

   logic [N_WORDS-1:0][FW-1:0] live_q;
   logic [SW-1:0]              sum;

   always_comb begin
      sum = '0;
      for (int w = 0; w < N_WORDS; w++) begin
         live_nxt[w] = clr ? '0 : live_q[w];
         if (hit && (idx == IDX_W'(w))) begin
            for (int k = 0; k < N_THR; k++) begin
               sum = SW'(live_nxt[w][k*CNT_W +: CNT_W]) + SW'(incs[k*INC_W +: INC_W]);
               live_nxt[w][k*CNT_W +: CNT_W] =
                  (sum > SW'(C_MAX)) ? CNT_W'(C_MAX) : sum[CNT_W-1:0];
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) live_q <= '0;
      else        live_q <= live_nxt;
   end
endmodule

// File: rtl/tmc_emit.sv
module tmc_emit
   import thr_mult_pkg::*;
#(
   parameter int N_WORDS = 36,
   parameter int FW      = 12,
   parameter int IDX_W   = 6
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       load,
   input  logic [N_WORDS-1:0][FW-1:0] snap,
   output logic                       out_valid,
   output logic [FW-1:0]              out_word
);
   logic [N_WORDS-1:0][FW-1:0] shadow_q;
   logic [IDX_W-1:0]           rd_q;
   emit_st_e                   st_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow_q <= '0;
         rd_q     <= '0;
         st_q     <= EMIT_IDLE;
      end else if (load) begin
         shadow_q <= snap;
         rd_q     <= '0;
         st_q     <= EMIT_RUN;
      end else if (st_q == EMIT_RUN) begin
         if (rd_q == IDX_W'(N_WORDS - 1)) begin
            rd_q <= '0;
            st_q <= EMIT_IDLE;
         end else begin
            rd_q <= rd_q + 1'b1;
         end
      end
   end

   assign out_valid = (st_q == EMIT_RUN);
   assign out_word  = out_valid ? shadow_q[rd_q] : '0;
endmodule

// File: rtl/thr_mult_packer.sv
module thr_mult_packer #(
   parameter int N_ALG  = 3,
   parameter int N_ETA  = 4,
   parameter int N_REG  = 3,
   parameter int SLOTS  = 4,
   parameter int CODE_W = 3,
   parameter int N_THR  = 6,
   parameter int CNT_W  = 2
) (
   input  logic                                          clk,
   input  logic                                          rst_n,
   input  logic                                          sof,
   input  logic                                          eof,
   input  logic                                          in_valid,
   input  logic [((N_ALG > 1) ? $clog2(N_ALG) : 1)-1:0]  in_alg,
   input  logic [((N_ETA > 1) ? $clog2(N_ETA) : 1)-1:0]  in_eta,
   input  logic [((N_REG > 1) ? $clog2(N_REG) : 1)-1:0]  in_reg,
   input  logic [CODE_W*SLOTS-1:0]                       in_word,
   output logic                                          out_valid,
   output logic [N_THR*CNT_W-1:0]                        out_word,
   output logic                                          tag_err
);
   localparam int AW      = (N_ALG > 1) ? $clog2(N_ALG) : 1;
   localparam int RW      = (N_REG > 1) ? $clog2(N_REG) : 1;
   localparam int N_WORDS = N_ALG * N_ETA * N_REG;
   localparam int IDX_W   = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
   localparam int INC_W   = $clog2(SLOTS + 1);
   localparam int FW      = N_THR * CNT_W;

   if (N_THR > (1 << CODE_W) - 1) begin : g_bad_thr
      $error("thr_mult_packer: N_THR exceeds the code range");
   end
   if (CODE_W > thr_mult_pkg::TMC_MAX_THR_BITS + 5) begin : g_bad_code
      $error("thr_mult_packer: CODE_W out of range");
   end

   logic reg_ok, alg_ok, hit, err_q;
   logic [IDX_W-1:0]              idx;
   logic [N_THR*INC_W-1:0]        incs;
   logic [N_WORDS-1:0][FW-1:0]    live_nxt;

   if ((1 << RW) == N_REG) begin : g_reg_full
      assign reg_ok = 1'b1;
   end else begin : g_reg_cmp
      assign reg_ok = (in_reg < RW'(N_REG));
   end
   if ((1 << AW) == N_ALG) begin : g_alg_full
      assign alg_ok = 1'b1;
   end else begin : g_alg_cmp
      assign alg_ok = (in_alg < AW'(N_ALG));
   end

   assign hit = in_valid && reg_ok && alg_ok;
   assign idx = IDX_W'((32'(in_alg) * N_ETA + 32'(in_eta)) * N_REG + 32'(in_reg));

   tmc_unpack #(.CODE_W(CODE_W), .SLOTS(SLOTS), .N_THR(N_THR), .INC_W(INC_W)) u_unpack (
      .word (in_word),
      .incs (incs)
   );

   tmc_acc #(.N_WORDS(N_WORDS), .N_THR(N_THR), .CNT_W(CNT_W), .INC_W(INC_W), .IDX_W(IDX_W)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (sof),
      .hit      (hit),
      .idx      (idx),
      .incs     (incs),
      .live_nxt (live_nxt)
   );

   tmc_emit #(.N_WORDS(N_WORDS), .FW(FW), .IDX_W(IDX_W)) u_emit (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (eof),
      .snap      (live_nxt),
      .out_valid (out_valid),
      .out_word  (out_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                  err_q <= 1'b0;
      else if (in_valid && !hit)   err_q <= 1'b1;
   end
   assign tag_err = err_q;
endmodule

// File: rtl/thr_mult_packer_chk.sv
module thr_mult_packer_chk #(
   parameter int N_WORDS = 36,
   parameter int N_ALG   = 3,
   parameter int N_REG   = 3,
   parameter int AW      = 2,
   parameter int RW      = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          eof,
   input logic          in_valid,
   input logic [AW-1:0] in_alg,
   input logic [RW-1:0] in_reg,
   input logic          out_valid,
   input logic          tag_err
);
   logic [15:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n || eof) run_q <= '0;
      else if (out_valid) run_q <= run_q + 1'b1;
   end

   assert_eof_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
      eof |=> out_valid);

   assert_burst_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_valid) |-> (run_q == 16'(N_WORDS)));

   assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tag_err |=> tag_err);

   assert_err_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ((32'(in_reg) >= N_REG) || (32'(in_alg) >= N_ALG))) |=> tag_err);
endmodule

bind thr_mult_packer thr_mult_packer_chk #(
   .N_WORDS (N_WORDS),
   .N_ALG   (N_ALG),
   .N_REG   (N_REG),
   .AW      (AW),
   .RW      (RW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .eof       (eof),
   .in_valid  (in_valid),
   .in_alg    (in_alg),
   .in_reg    (in_reg),
   .out_valid (out_valid),
   .tag_err   (tag_err)
);

// File: tb/sim_thr_mult_packer.sv
module sim_thr_mult_packer;
   logic        clk = 1'b0;
   logic        rst_n, sof, eof, in_valid;
   logic [1:0]  in_alg, in_eta, in_reg;
   logic [11:0] in_word;
   logic        out_valid, tag_err;
   logic [11:0] out_word;

   int total = 0;
   int bad   = 0;
   bit done  = 0;
   int live [36][6];
   int snap [36][6];
   int pos   = -1;
   bit exp_err = 0;
   string cur_req = "R2";
   logic [15:0] lfsr = 16'hACE1;

   always #4 clk = ~clk;

   thr_mult_packer u0 (
      .clk(clk), .rst_n(rst_n), .sof(sof), .eof(eof), .in_valid(in_valid),
      .in_alg(in_alg), .in_eta(in_eta), .in_reg(in_reg), .in_word(in_word),
      .out_valid(out_valid), .out_word(out_word), .tag_err(tag_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, expv, $time);
      end
   endtask

   function automatic logic [11:0] pack(input int n);
      logic [11:0] r = '0;
      for (int k = 0; k < 6; k++) r[2*k +: 2] = 2'(snap[n][k]);
      return r;
   endfunction

   task automatic clear_live();
      for (int i = 0; i < 36; i++) for (int k = 0; k < 6; k++) live[i][k] = 0;
   endtask

   // one clock: drive at a falling edge, update model, check at the next falling edge
   task automatic step(input bit s, input bit e, input bit v, input int a, input int et,
                       input int r, input logic [11:0] w);
      sof = s; eof = e; in_valid = v;
      in_alg = 2'(a); in_eta = 2'(et); in_reg = 2'(r); in_word = w;
      if (s) clear_live();
      if (v) begin
         if (a < 3 && r < 3) begin
            int id = (a * 4 + et) * 3 + r;
            for (int sl = 0; sl < 4; sl++) begin
               int c = int'(w[3*sl +: 3]);
               for (int k = 1; k <= 6; k++)
                  if (c >= k && live[id][k-1] < 3) live[id][k-1]++;
            end
         end else exp_err = 1;
      end
      if (e) begin
         snap = live;
         pos = 0;
      end else if (pos >= 0) pos = (pos == 35) ? -1 : pos + 1;
      @(negedge clk);
      chk(out_valid == (pos >= 0), "R6", int'(out_valid), int'(pos >= 0));
      if (pos >= 0) chk(out_word == pack(pos), cur_req, int'(out_word), int'(pack(pos)));
      chk(tag_err == exp_err, "R7", int'(tag_err), int'(exp_err));
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 0, 0, '0);
   endtask

   task automatic burst();
      step(0, 1, 0, 0, 0, 0, '0);
      for (int i = 0; i < 36; i++) idle();
   endtask

   task automatic rnd_step(input bit s, input bit e, input bit allow_bad);
      int a, r;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = int'(lfsr[1:0]);
      r = int'(lfsr[5:4]);
      if (!allow_bad) begin
         if (a == 3) a = 0;
         if (r == 3) r = 2;
      end
      step(s, e, lfsr[8] | lfsr[9], a, int'(lfsr[3:2]), r, {lfsr[15:10], lfsr[7:2]});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 0; sof = 0; eof = 0; in_valid = 0;
      in_alg = 0; in_eta = 0; in_reg = 0; in_word = 0;
      clear_live();
      repeat (3) @(negedge clk);
      chk(out_valid == 0, "R1", int'(out_valid), 0);
      chk(out_word == 0, "R1", int'(out_word), 0);
      chk(tag_err == 0, "R1", int'(tag_err), 0);
      rst_n = 1;
      @(negedge clk);
      chk(out_valid == 0 && tag_err == 0, "R1", int'({out_valid, tag_err}), 0);

      // R2: every code value in every slot, alone in a frame
      cur_req = "R2";
      for (int c = 0; c < 8; c++)
         for (int s = 0; s < 4; s++) begin
            int n = (c * 4 + s) % 36;
            step(1, 0, 0, 0, 0, 0, '0);
            step(0, 0, 1, n / 12, (n / 3) % 4, n % 3, 12'(c) << (3 * s));
            burst();
         end

      // R3: distinct per-threshold counts expose field positions
      cur_req = "R3";
      step(1, 0, 1, 2, 3, 1, {3'd0, 3'd4, 3'd2, 3'd1});
      step(0, 0, 1, 1, 0, 2, {3'd6, 3'd3, 3'd0, 3'd0});
      burst();

      // R4: saturation
      cur_req = "R4";
      step(1, 0, 0, 0, 0, 0, '0);
      for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 2, 0, 12'hFFF);
      step(0, 0, 1, 2, 0, 2, {3'd2, 3'd2, 3'd2, 3'd2});
      burst();

      // R9: accumulation over several words at one address
      cur_req = "R9";
      step(1, 0, 1, 1, 1, 1, {3'd0, 3'd0, 3'd0, 3'd3});
      step(0, 0, 1, 1, 1, 1, {3'd0, 3'd5, 3'd0, 3'd0});
      burst();

      // R5: input together with sof lands in the new frame only
      cur_req = "R5";
      step(0, 0, 1, 0, 0, 0, 12'h249);
      step(1, 0, 1, 2, 2, 2, {3'd0, 3'd1, 3'd0, 3'd0});
      burst();

      // R6: input together with eof is included; eof mid-burst restarts
      cur_req = "R6";
      step(1, 0, 0, 0, 0, 0, '0);
      step(0, 1, 1, 0, 3, 1, {3'd7, 3'd0, 3'd0, 3'd2});
      for (int i = 0; i < 10; i++) idle();
      step(0, 1, 1, 1, 2, 0, {3'd0, 3'd0, 3'd4, 3'd0});
      for (int i = 0; i < 36; i++) idle();

      // R8: inputs during a burst reach the next snapshot only
      cur_req = "R8";
      step(1, 0, 1, 0, 1, 2, {3'd1, 3'd1, 3'd0, 3'd0});
      step(0, 1, 0, 0, 0, 0, '0);
      for (int i = 0; i < 36; i++) step(0, 0, 1, i / 12, (i / 3) % 4, i % 3, 12'(i * 37));
      burst();

      // R7: invalid tags ignored, flag sticky
      cur_req = "R7";
      step(1, 0, 1, 0, 0, 1, {3'd3, 3'd3, 3'd3, 3'd3});
      chk(tag_err == 0, "R7", int'(tag_err), 0);
      step(0, 0, 1, 0, 0, 3, 12'hFFF);
      step(0, 0, 1, 3, 0, 0, 12'hFFF);
      idle();
      burst();
      step(1, 0, 0, 0, 0, 0, '0);
      chk(tag_err == 1, "R7", int'(tag_err), 1);

      // R9 sweep: pseudo-random frames, inputs also during bursts and with sof/eof
      cur_req = "R9";
      for (int f = 0; f < 8; f++) begin
         rnd_step(1, 0, 1);
         for (int i = 0; i < 40; i++) rnd_step(0, 0, 1);
         rnd_step(0, 1, 1);
         for (int i = 0; i < 36; i++) rnd_step(0, 0, 1);
      end
      idle();

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule